// File: doc/BRIEF.md
# Single-Read Bus Master with Slave-State Write Service

This block is the processor side of a system bus on which address and data share one set of wires. A core asks for one read through a valid/ready request port. The block spends one cycle presenting the read on the bus. In that cycle it drives the read command and the address and pulls the active-low processor-valid strobe low. It then hands the bus to the external agent by raising its active-low master indicator, and it stops driving the shared wires.

While it waits in slave state, the external agent owns the bus. It may send any number of write transactions, and the block passes each of them to a side port. The wait ends in one of two ways. The agent may return the read data, tagged with a read-response identifier. Or a programmable cycle count may run out, in which case the block reports an error instead of data. Either way the block spends one handback cycle as master again, and that cycle carries a one-cycle completion pulse to the core. Only then does it accept the next request.

Back-pressure rules: a request transfers on a clock edge where `rq_valid` and `rq_ready` are both high, and `rq_addr` is captured on that edge. `rq_ready` stays low from that edge until the completion pulse has been given. The completion and write side ports have no ready signal and are single-cycle pulses.

Top module: `rdreq_bus_master`

## Requirements
- R1: After reset, `pmaster_n`=0, `pvalid_n`=1, `ad_oe`=0, `cmd_oe`=0, `rq_ready`=1, `rsp_valid`=0 and `wr_valid`=0.
- R2: In the cycle after a request handshake, the block drives the issue cycle for exactly one cycle. In that cycle `pvalid_n`=0, `cmd_o`=8'h40 (read command), `ad_o` holds the captured address, both output enables are 1 and `pmaster_n` is still 0.
- R3: From the cycle after the issue cycle until the read ends, the block is in slave state. There `pmaster_n`=1, `pvalid_n`=1 and both output enables are 0.
- R4: Only one read is outstanding. `rq_ready` is 0 from the issue cycle through the handback cycle, and `rq_valid` is ignored in that span.
- R5: A read response is a slave-state cycle with `evalid_n`=0, `cmd_i[7:6]`=2'b11 (data identifier) and `cmd_i[5]`=1 (read data). In the next cycle `rsp_valid`=1 for one cycle, with `rsp_data` = the `ad_i` of the response cycle, `rsp_err`=0 and `pmaster_n`=0. The cycle after that, `rq_ready`=1.
- R6: In slave state, an external write is two cycles with `evalid_n`=0. The first carries `cmd_i[7:6]`=2'b10 with the address on `ad_i`. The second carries `cmd_i[7:6]`=2'b11 and `cmd_i[5]`=0 with the data on `ad_i`. The cycle after the data cycle, `wr_valid`=1 for one cycle with `wr_addr` and `wr_data`. Any number of writes may precede the response, and none of them ends the read.
- R7: `tmo_limit` is sampled in the issue cycle. If it is L≠0 and no response arrives in the first L slave cycles, the cycle after the L-th slave cycle gives `rsp_valid`=1, `rsp_err`=1 and `rsp_data`=0. A response in the L-th slave cycle wins over the timeout.
- R8: A sampled limit of 0 disables the timeout, and the block waits for a response indefinitely.
- R9: External write cycles do not restart the timeout count.
- R10: `evalid_n` cycles outside slave state are ignored. A write data cycle with no pending write address produces no `wr_valid`.
- R11: A request is taken only on a `rq_valid`&&`rq_ready` edge. A request held high across a completion is taken in the first cycle `rq_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_valid | input | 1 | Core read request valid |
| rq_ready | output | 1 | Block can take a request |
| rq_addr | input | 32 | Read address |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a timeout |
| rsp_data | output | 32 | Read data (0 on timeout) |
| tmo_limit | input | 16 | Timeout in slave cycles, 0 = off |
| wr_valid | output | 1 | External write forwarded |
| wr_addr | output | 32 | External write address |
| wr_data | output | 32 | External write data |
| ad_o | output | 32 | Address/data bus drive value |
| ad_oe | output | 1 | Address/data bus output enable |
| ad_i | input | 32 | Address/data bus sampled value |
| cmd_o | output | 8 | Command bus drive value |
| cmd_oe | output | 1 | Command bus output enable |
| cmd_i | input | 8 | Command bus sampled value |
| pvalid_n | output | 1 | Processor-valid strobe, active low |
| pmaster_n | output | 1 | Processor-master indicator, active low |
| evalid_n | input | 1 | External-valid strobe, active low |

## Verification
The bench aims at the edges of the timeout window. It uses a limit of 1, and it sends a response in exactly the last allowed slave cycle. A counter that is off by one would then report an error one cycle early, or let a late response through. Writes are interleaved during a timed wait, so a design that restarted the count on each write would finish late. The bench also holds a request high across completions, sends strobes outside slave state and sends a data beat with no address. A design that took a second read early, or answered stray traffic, would show an unexpected issue cycle or an unexpected write pulse.

// File: rtl/rdreq_pkg.sv
package rdreq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_SLAVE = 2'd2,
    ST_HAND  = 2'd3
  } rd_state_e;

  localparam logic [1:0] KIND_READ  = 2'b01;
  localparam logic [1:0] KIND_WRITE = 2'b10;
  localparam logic [1:0] KIND_DATA  = 2'b11;
  localparam logic [7:0] CMD_READ   = 8'h40;
  localparam int         RESP_BIT   = 5;
endpackage

// File: rtl/rdreq_tmo.sv
module rdreq_tmo #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
      lim_q <= limit;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = run && (lim_q != '0) && (cnt_q == lim_q - 1'b1);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && lim_q != '0) |-> (cnt_q < lim_q)); // R7
endmodule

// File: rtl/rdreq_ewr.sv
module rdreq_ewr #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          flush,
  input  logic          evalid_n,
  input  logic [CW-1:0] cmd_i,
  input  logic [DW-1:0] ad_i,
  output logic          wr_valid,
  output logic [DW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  import rdreq_pkg::*;

  logic          pend_q;
  logic [DW-1:0] wa_q;
  logic [1:0]    kind;

  assign kind = cmd_i[CW-1 -: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      wa_q     <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (flush) begin
        pend_q <= 1'b0;
      end else if (enable && !evalid_n) begin
        if (kind == KIND_WRITE) begin
          wa_q   <= ad_i;
          pend_q <= 1'b1;
        end else if (kind == KIND_DATA && !cmd_i[RESP_BIT] && pend_q) begin
          wr_valid <= 1'b1;
          wr_addr  <= wa_q;
          wr_data  <= ad_i;
          pend_q   <= 1'b0;
        end
      end
    end
  end

  AST_WR_ONLY_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(enable)); // R10
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R6
endmodule

// File: rtl/rdreq_ctl.sv
module rdreq_ctl #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rq_valid,
  input  logic [DW-1:0] rq_addr,
  output logic          rq_ready,
  input  logic          evalid_n,
  input  logic [CW-1:0] cmd_i,
  input  logic [DW-1:0] ad_i,
  input  logic          expire,
  output logic          in_issue,
  output logic          in_slave,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_data,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  output logic [CW-1:0] cmd_o,
  output logic          cmd_oe,
  output logic          pvalid_n,
  output logic          pmaster_n
);
  import rdreq_pkg::*;

  rd_state_e     st_q;
  logic [DW-1:0] addr_q;
  logic          rsp_hit;

  assign rsp_hit = (st_q == ST_SLAVE) && !evalid_n &&
                   (cmd_i[CW-1 -: 2] == KIND_DATA) && cmd_i[RESP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      rsp_err  <= 1'b0;
      rsp_data <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (rq_valid) begin
          addr_q <= rq_addr;
          st_q   <= ST_ISSUE;
        end
        ST_ISSUE: st_q <= ST_SLAVE;
        ST_SLAVE: if (rsp_hit) begin
          rsp_data <= ad_i;
          rsp_err  <= 1'b0;
          st_q     <= ST_HAND;
        end else if (expire) begin
          rsp_data <= '0;
          rsp_err  <= 1'b1;
          st_q     <= ST_HAND;
        end
        ST_HAND: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_issue  = (st_q == ST_ISSUE);
  assign in_slave  = (st_q == ST_SLAVE);
  assign rq_ready  = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_HAND);
  assign pvalid_n  = !in_issue;
  assign pmaster_n = in_slave;
  assign ad_oe     = in_issue;
  assign cmd_oe    = in_issue;
  assign ad_o      = in_issue ? addr_q : '0;
  assign cmd_o     = in_issue ? CMD_READ : '0;

  AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pvalid_n |=> pvalid_n); // R2
  AST_SLAVE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !pvalid_n |=> pmaster_n); // R3
  AST_NO_DRIVE_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    pmaster_n |-> (!ad_oe && !cmd_oe)); // R3
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_ready && rq_valid) |=> (!rq_ready && !pvalid_n)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && rq_ready)); // R5
  AST_HANDBACK_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(pmaster_n) && !pmaster_n)); // R5
endmodule

// File: rtl/rdreq_bus_master.sv
module rdreq_bus_master #(
  parameter int DW = 32,
  parameter int CW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rq_valid,
  output logic          rq_ready,
  input  logic [DW-1:0] rq_addr,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_data,
  input  logic [TW-1:0] tmo_limit,
  output logic          wr_valid,
  output logic [DW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_i,
  output logic [CW-1:0] cmd_o,
  output logic          cmd_oe,
  input  logic [CW-1:0] cmd_i,
  output logic          pvalid_n,
  output logic          pmaster_n,
  input  logic          evalid_n
);
  logic in_issue;
  logic in_slave;
  logic expire;

  rdreq_ctl #(.DW(DW), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_ready(rq_ready),
    .evalid_n(evalid_n), .cmd_i(cmd_i), .ad_i(ad_i), .expire(expire),
    .in_issue(in_issue), .in_slave(in_slave),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .ad_o(ad_o), .ad_oe(ad_oe), .cmd_o(cmd_o), .cmd_oe(cmd_oe),
    .pvalid_n(pvalid_n), .pmaster_n(pmaster_n)
  );

  rdreq_tmo #(.TW(TW)) u_tmo (
    .clk(clk), .rst_n(rst_n),
    .start(in_issue), .run(in_slave), .limit(tmo_limit), .expire(expire)
  );

  rdreq_ewr #(.DW(DW), .CW(CW)) u_ewr (
    .clk(clk), .rst_n(rst_n),
    .enable(in_slave), .flush(in_issue),
    .evalid_n(evalid_n), .cmd_i(cmd_i), .ad_i(ad_i),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: tb/rdreq_bus_master_test.sv
module rdreq_bus_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rq_valid = 1'b0;
  logic [31:0] rq_addr = '0;
  logic [15:0] tmo_limit = '0;
  logic [31:0] ad_i = '0;
  logic [7:0]  cmd_i = '0;
  logic        evalid_n = 1'b1;
  logic        rq_ready, rsp_valid, rsp_err, wr_valid, ad_oe, cmd_oe, pvalid_n, pmaster_n;
  logic [31:0] rsp_data, wr_addr, wr_data, ad_o;
  logic [7:0]  cmd_o;

  rdreq_bus_master uut (
    .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data), .tmo_limit(tmo_limit),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_i(cmd_i),
    .pvalid_n(pvalid_n), .pmaster_n(pmaster_n), .evalid_n(evalid_n)
  );

  always #5 clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string tag = "R1";
  bit    first = 1'b1;

  // behavioural reference: flags for the bus phase plus wait and write bookkeeping
  bit          m_issue, m_slave, m_done, m_err, m_wv, m_pend;
  int          m_waited, m_lim;
  logic [31:0] m_addr, m_rdata, m_wa, m_wadr, m_wdat;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_issue = 0; m_slave = 0; m_done = 0; m_err = 0; m_wv = 0; m_pend = 0;
      m_waited = 0; m_lim = 0;
    end else begin
      bit ready, resp, tmo, take;
      ready = !m_issue && !m_slave && !m_done;
      resp  = m_slave && !evalid_n && cmd_i[7:6] == 2'b11 && cmd_i[5];
      tmo   = m_slave && !resp && m_lim != 0 && m_waited == m_lim - 1;
      take  = ready && rq_valid;
      m_wv  = 0;
      if (m_slave && !evalid_n && cmd_i[7:6] == 2'b10) begin
        m_wa = ad_i; m_pend = 1;
      end else if (m_slave && !evalid_n && cmd_i[7:6] == 2'b11 && !cmd_i[5] && m_pend) begin
        m_wv = 1; m_wadr = m_wa; m_wdat = ad_i; m_pend = 0;
      end
      if (m_issue) begin m_waited = 0; m_lim = tmo_limit; m_pend = 0; end
      else if (m_slave) m_waited++;
      m_done = resp || tmo;
      if (resp) begin m_rdata = ad_i; m_err = 0; end
      if (tmo)  begin m_rdata = 0;    m_err = 1; end
      m_slave = m_issue || (m_slave && !m_done);
      if (take) m_addr = rq_addr;
      m_issue = take;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (%s) cycle %0d: actual %h expected %h", req, tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (first) begin
        // R1 reset state
        chk(pmaster_n == 0 && pvalid_n == 1 && !ad_oe && !cmd_oe && rq_ready && !rsp_valid && !wr_valid,
            "R1", {pmaster_n, pvalid_n, ad_oe, cmd_oe, rq_ready, rsp_valid, wr_valid}, 7'b0100100);
        first = 0;
      end
      chk(pvalid_n == !m_issue && ad_oe == m_issue && cmd_oe == m_issue, "R2",
          {pvalid_n, ad_oe, cmd_oe}, {!m_issue, m_issue, m_issue});
      if (m_issue) chk(cmd_o == 8'h40 && ad_o == m_addr, "R2", {cmd_o, ad_o}, {8'h40, m_addr});
      chk(pmaster_n == m_slave, "R3", pmaster_n, m_slave);
      chk(rq_ready == (!m_issue && !m_slave && !m_done), "R4", rq_ready, !m_issue && !m_slave && !m_done);
      chk(rsp_valid == m_done, "R5", rsp_valid, m_done);
      if (m_done) chk(rsp_err == m_err && rsp_data == m_rdata, m_err ? "R7" : "R5",
                      {rsp_err, rsp_data}, {m_err, m_rdata});
      chk(wr_valid == m_wv, "R6", wr_valid, m_wv);
      if (m_wv) chk(wr_addr == m_wadr && wr_data == m_wdat, "R6", {wr_addr, wr_data}, {m_wadr, m_wdat});
    end
  end

  task automatic drv(input bit rv, input logic [31:0] a, input bit evn, input logic [7:0] c, input logic [31:0] d);
    @(negedge clk); #1;
    rq_valid = rv; rq_addr = a; evalid_n = evn; cmd_i = c; ad_i = d;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(0, 0, 1, 0, 0);
  endtask
  task automatic req(input logic [31:0] a, input logic [15:0] lim);
    tmo_limit = lim;
    drv(1, a, 1, 0, 0);
    drv(0, 0, 1, 0, 0);          // issue cycle
  endtask
  task automatic resp(input logic [31:0] d);
    drv(0, 0, 0, 8'hE0, d);      // data id, read-data type
  endtask
  task automatic ewrite(input logic [31:0] a, input logic [31:0] d);
    drv(0, 0, 0, 8'h80, a);
    drv(0, 0, 0, 8'hC0, d);      // data id, write-data type
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);
    tag = "R2/R3/R5/R8"; req(32'h1000_0004, 0); idle(3); resp(32'hCAFE_0001); idle(3);
    tag = "R6"; req(32'h2000_0008, 20); ewrite(32'hA0, 32'h11); idle(1);
    ewrite(32'hA4, 32'h22); resp(32'hBEEF_0002); idle(2);
    tag = "R7/R9"; req(32'h3000_0000, 8); ewrite(32'hB0, 32'h33); ewrite(32'hB4, 32'h44); idle(8);
    tag = "R7 limit 1"; req(32'h4000_0000, 1); idle(4);
    tag = "R7 last-cycle response"; req(32'h5000_0000, 4); idle(3); resp(32'h5555_AAAA); idle(2);
    tag = "R10"; drv(0, 0, 0, 8'hE0, 32'h9); drv(0, 0, 0, 8'h80, 32'h9); drv(0, 0, 0, 8'hC0, 32'h9);
    req(32'h6000_0000, 0); drv(0, 0, 0, 8'hC0, 32'h77); drv(0, 0, 1, 8'hE0, 32'h66); idle(2);
    resp(32'h6666_0000); idle(2);
    tag = "R4/R11"; tmo_limit = 3;
    for (int i = 0; i < 12; i++) drv(1, 32'h7000_0000 + i, 1, 0, 0);
    drv(1, 32'h7100_0000, 1, 0, 0); drv(1, 32'h7100_0000, 1, 0, 0);
    resp(32'h7777_0000); drv(0, 0, 1, 0, 0);
    tag = "R8"; req(32'h8000_0000, 0); idle(40); resp(32'h8888_0000); idle(3);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (%s): actual running expected finished", tag);
    summary();
  end
endmodule